// File: doc/BRIEF.md
# Staggered Three-Unit Converter Start Sequencer

This block starts three identical sampling converters one after another, so their samples interleave. When a run request arrives and the block is idle, it raises the run level of unit 0 at once. It raises unit 1 a programmed number of system clocks later, and unit 2 the same number of clocks after that. Once a unit's run level is high, it stays high and the unit converts without pause. The three units then sample in turn, and the combined sample rate is three times that of one unit.

The best spacing is one third of a unit's steady-state conversion period, rounded to whole clocks. With a 2.56 µs period and a 50 MHz clock, that is 128 / 3, which rounds to 43 cycles (0.86 µs). The gap from unit 2 back to unit 0 then comes out at 0.84 µs, so the sample intervals are not perfectly even. The first conversion after a start runs longer than the later ones, so only the steady-state period should be used to choose the spacing.

Each unit has its own stop input, which is normally driven by that unit's transfer-complete event. A stop clears only that unit's run level. The busy output covers the whole sequence, from the first start until the last running unit stops.

Top module: `stagger_start_seq`

## Requirements
- R1: After reset, all run levels and busy are low.
- R2: While idle, a high `run_req` sampled on a clock edge raises `unit_run[0]` and `busy` on that same edge. Units start strictly in the order 0, 1, 2.
- R3: For a nonzero spacing G, `unit_run[1]` rises exactly G cycles after `unit_run[0]`, and `unit_run[2]` rises exactly G cycles after `unit_run[1]`. This holds for any G from 1 to 255.
- R4: A spacing of 0 raises all three run levels on the same edge as the launch.
- R5: The spacing is captured at launch. Changes to `spacing` during a launch do not alter the start times.
- R6: While `busy` is high, `run_req` has no effect: no unit is started again, and a unit that has stopped stays stopped.
- R7: When `stop_evt[i]` is high on an edge while `unit_run[i]` is high, `unit_run[i]` falls on that edge. The other units are not affected.
- R8: `busy` falls on the same edge as the last running unit stops, provided every unit has already started. It is never low while a run level is high.
- R9: `stop_evt[i]` for a unit that has not yet started is ignored. That unit still starts at its scheduled time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req | input | 1 | Level request to launch the start sequence; sampled only while idle |
| spacing | input | 8 | Gap between consecutive unit starts, in clock cycles |
| stop_evt | input | 3 | Per-unit stop request (one bit per unit, bit i for unit i) |
| unit_run | output | 3 | Per-unit run level (bit i for unit i) |
| busy | output | 1 | High from the first start until every unit has stopped |

## Verification
The embedded assertions check the following on every cycle:
- a running unit is never started again;
- a stop clears its unit on the next edge;
- a non-simultaneous launch never starts two units on one edge;
- the gap counter never passes the captured spacing;
- busy is never low while any unit runs.

Only the directed scenarios can show the exact start cycles for spacings of 0, 1, 43 and 255. The same holds for the insensitivity to a spacing change in mid-launch, for the ignored run requests, and for the ignored early stops, because these compare absolute cycle positions against values computed in the bench.

// File: rtl/stagger_pkg.sv
package stagger_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_LAUNCH  = 2'd1,
    SEQ_RUNNING = 2'd2
  } seq_state_t;
endpackage

// File: rtl/stagger_gap_timer.sv
module stagger_gap_timer #(
  parameter int N_UNITS = 3,
  parameter int SPACE_W = 8,
  localparam int IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch_i,
  input  logic [SPACE_W-1:0] spacing_i,
  output logic [N_UNITS-1:0] start_o,
  output logic               last_start_o
);
  logic               active_q;
  logic [SPACE_W-1:0] gap_q;
  logic [SPACE_W-1:0] cnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic               gap_hit;

  function automatic logic gap_reached(input logic [SPACE_W-1:0] c,
                                       input logic [SPACE_W-1:0] g);
    return c == g;
  endfunction

  function automatic logic is_last(input logic [IDX_W-1:0] i);
    return i == IDX_W'(N_UNITS - 1);
  endfunction

  assign gap_hit = active_q && gap_reached(cnt_q, gap_q);

  always_comb begin
    start_o = '0;
    if (launch_i) begin
      if (spacing_i == '0) start_o = '1;
      else                 start_o[0] = 1'b1;
    end else if (gap_hit) begin
      for (int k = 0; k < N_UNITS; k++)
        if (idx_q == IDX_W'(k)) start_o[k] = 1'b1;
    end
  end

  assign last_start_o = start_o[N_UNITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      gap_q    <= '0;
      cnt_q    <= '0;
      idx_q    <= '0;
    end else if (launch_i) begin
      gap_q    <= spacing_i;
      cnt_q    <= SPACE_W'(1);
      idx_q    <= IDX_W'(1);
      active_q <= (spacing_i != '0) && (N_UNITS > 1);
    end else if (active_q) begin
      if (gap_hit) begin
        cnt_q <= SPACE_W'(1);
        idx_q <= idx_q + IDX_W'(1);
        if (is_last(idx_q)) active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + SPACE_W'(1);
      end
    end
  end

  // R3
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q <= gap_q && cnt_q != '0));

  // R2
  one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch_i) |-> $onehot0(start_o));

  // R4
  zero_gap_no_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> gap_q != '0);
endmodule

// File: rtl/stagger_run_ctl.sv
module stagger_run_ctl #(
  parameter int N_UNITS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_UNITS-1:0] start_i,
  input  logic [N_UNITS-1:0] stop_i,
  output logic [N_UNITS-1:0] run_o
);
  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           run_o[u] <= 1'b0;
      else if (start_i[u])  run_o[u] <= 1'b1;
      else if (stop_i[u])   run_o[u] <= 1'b0;
    end

    // R6
    no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_o[u] |-> !start_i[u]);

    // R7
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o[u] && stop_i[u]) |=> !run_o[u]);
  end
endmodule

// File: rtl/stagger_seq_fsm.sv
module stagger_seq_fsm
  import stagger_pkg::*;
#(
  parameter int N_UNITS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_req_i,
  input  logic               last_start_i,
  input  logic [N_UNITS-1:0] run_i,
  input  logic [N_UNITS-1:0] stop_i,
  output logic               launch_o,
  output logic               busy_o
);
  seq_state_t state_q, state_d;
  logic       drain_done;

  function automatic logic none_left(input logic [N_UNITS-1:0] r,
                                     input logic [N_UNITS-1:0] s);
    return (r & ~s) == '0;
  endfunction

  assign launch_o   = (state_q == SEQ_IDLE) && run_req_i;
  assign drain_done = none_left(run_i, stop_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:    if (launch_o) state_d = last_start_i ? SEQ_RUNNING : SEQ_LAUNCH;
      SEQ_LAUNCH:  if (last_start_i) state_d = SEQ_RUNNING;
      SEQ_RUNNING: if (drain_done) state_d = SEQ_IDLE;
      default:     state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign busy_o = (state_q != SEQ_IDLE);

  // R8
  busy_covers_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o) |-> (run_i == '0));
endmodule

// File: rtl/stagger_start_seq.sv
module stagger_start_seq #(
  parameter int N_UNITS = 3,
  parameter int SPACE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_req,
  input  logic [SPACE_W-1:0] spacing,
  input  logic [N_UNITS-1:0] stop_evt,
  output logic [N_UNITS-1:0] unit_run,
  output logic               busy
);
  logic               launch;
  logic               last_start;
  logic [N_UNITS-1:0] start_vec;

  stagger_gap_timer #(.N_UNITS(N_UNITS), .SPACE_W(SPACE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .spacing_i(spacing),
    .start_o(start_vec), .last_start_o(last_start)
  );

  stagger_run_ctl #(.N_UNITS(N_UNITS)) u_run (
    .clk(clk), .rst_n(rst_n), .start_i(start_vec), .stop_i(stop_evt),
    .run_o(unit_run)
  );

  stagger_seq_fsm #(.N_UNITS(N_UNITS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .run_req_i(run_req), .last_start_i(last_start),
    .run_i(unit_run), .stop_i(stop_evt), .launch_o(launch), .busy_o(busy)
  );
endmodule

// File: tb/stagger_start_seq_bench.sv
module stagger_start_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_req = 1'b0;
  logic [7:0] spacing = 8'd0;
  logic [2:0] stop_evt = 3'b000;
  logic [2:0] unit_run;
  logic       busy;
  int         n_checks = 0;
  int         n_errors = 0;

  always #2 clk = ~clk;

  stagger_start_seq u_stagger_start_seq (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .spacing(spacing),
    .stop_evt(stop_evt), .unit_run(unit_run), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Launch with gap, optionally change spacing / pulse stops mid-launch; record rise cycles
  task automatic launch_timed(input int gap, input int chg_at, input int new_gap,
                              input int stop_at, input logic [2:0] stop_mask,
                              output int t [3]);
    for (int k = 0; k < 3; k++) t[k] = -1;
    @(negedge clk);
    spacing = 8'(gap);
    run_req = 1'b1;
    for (int c = 0; c <= 2 * gap + 4; c++) begin
      @(posedge clk); #1;
      for (int k = 0; k < 3; k++) if (t[k] < 0 && unit_run[k]) t[k] = c;
      if (c == 0) begin
        run_req = 1'b0;
        check("R2 busy at launch", int'(busy), 1);
      end
      if (c == chg_at) spacing = 8'(new_gap);
      if (c == stop_at) stop_evt = stop_mask;
      if (c == stop_at + 1) stop_evt = 3'b000;
    end
  endtask

  task automatic stop_units(input logic [2:0] m);
    @(negedge clk); stop_evt = m;
    @(posedge clk); #1; stop_evt = 3'b000;
  endtask

  task automatic test_reset();
    check("R1 run after reset", int'(unit_run), 0);
    check("R1 busy after reset", int'(busy), 0);
  endtask

  task automatic test_gap(input int gap);
    int t [3];
    launch_timed(gap, -1, 0, -1, 3'b000, t);
    check("R2 unit0 rise", t[0], 0);
    check("R3 unit1 rise", t[1], gap);
    check("R3 unit2 rise", t[2], 2 * gap);
    stop_units(3'b111);
    check("R8 busy after all stop", int'(busy), 0);
  endtask

  task automatic test_zero_gap();
    int t [3];
    launch_timed(0, -1, 0, -1, 3'b000, t);
    check("R4 unit0 rise", t[0], 0);
    check("R4 unit1 rise", t[1], 0);
    check("R4 unit2 rise", t[2], 0);
    stop_units(3'b111);
  endtask

  task automatic test_capture();
    int t [3];
    launch_timed(10, 3, 2, -1, 3'b000, t);
    check("R5 unit1 rise", t[1], 10);
    check("R5 unit2 rise", t[2], 20);
    stop_units(3'b111);
  endtask

  task automatic test_early_stop();
    int t [3];
    launch_timed(20, -1, 0, 5, 3'b100, t);
    check("R9 unit2 still starts", t[2], 40);
    check("R9 unit2 still running", int'(unit_run[2]), 1);
    stop_units(3'b111);
  endtask

  task automatic test_stops_and_ignore();
    int t [3];
    launch_timed(4, -1, 0, -1, 3'b000, t);
    @(negedge clk); run_req = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R6 no change under busy", int'(unit_run), 7);
    stop_units(3'b010);
    check("R7 only unit1 stops", int'(unit_run), 5);
    check("R8 busy while some run", int'(busy), 1);
    stop_units(3'b001);
    repeat (12) @(posedge clk);
    #1;
    check("R6 stopped unit stays off", int'(unit_run), 4);
    @(negedge clk); run_req = 1'b0;
    stop_units(3'b100);
    check("R8 busy falls with last stop", int'(busy), 0);
    check("R7 all off", int'(unit_run), 0);
  endtask

  initial begin
    #(4 * 200000);
    n_errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #1;
    test_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    test_gap(43);
    test_gap(1);
    test_gap(255);
    test_zero_gap();
    test_capture();
    test_early_stop();
    test_stops_and_ignore();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule